// File: doc/BRIEF.md
# Nibble Bus Register Front End

This block sits between a host processor and the internals of a 4-bit clock peripheral. The host reaches sixteen nibble-wide registers through a multiplexed bus. An address strobe captures the register number. Two chip selects of opposite polarity must both be active. Separate read and write strobes complete each access. Every bus pin is sampled on the system clock through a synchronizer chain, so the host strobes may be fully asynchronous to that clock.

Thirteen time-digit registers and the interrupt-setup register belong to neighbouring blocks. Reads from them go out through a combinational read port. Writes to them go out as a one-cycle pulse that carries the address and the data. The block itself owns two control registers. One holds the freeze request, the busy status, the interrupt flag view and the half-minute adjust request. The other holds the reset, stop and 24-hour bits.

The block also grants carry updates to the timekeeper. A grant is given only when no freeze is requested and the previous update window has run out. The window itself is what the host reads as busy.

Top module: `nbus_regif`

## Requirements
- R1: An access is accepted only while the active-low select `bus_cs0_n` is 0 and the active-high select `bus_cs1` is 1. A write strobe seen without both selects forwards nothing and changes no register. A read without both selects leaves `bus_doe` at 0.
- R2: While `bus_ale` is 1, the register address follows `bus_addr` directly. When `bus_ale` falls, the address present at that moment is held until `bus_ale` rises again. `ext_rd_addr` always presents this effective address.
- R3: `bus_doe` is 1 only while the chip is selected and `bus_rd_n` is 0, after the synchronizer delay. Whenever `bus_doe` is 0, `bus_dout` is 0.
- R4: A write takes effect when `bus_wr_n` rises. The address and data used are those present while `bus_wr_n` was last low. For addresses 0x0–0xC and 0xE, `ext_wr_o` pulses for exactly one cycle, with the address on `ext_wr_addr` and the data on `ext_wr_data`. Writes to 0xD and 0xF are never forwarded.
- R5: Reading address 0xD returns the freeze bit in bit 0, busy in bit 1 and `irq_flag_i` in bit 2. Bit 3 always reads 0.
- R6: Busy (0xD bit 1) is read-only, and writing it has no effect. Busy reads 1 for exactly BUSY_CYCLES cycles, starting with the cycle in which `carry_grant_o` pulses.
- R7: Writing 0xD with bit 2 = 0 pulses `irq_clr_o` for one cycle. Writing bit 2 = 1 produces no pulse, so the flag can only be cleared from the bus.
- R8: Writing 0xD with bit 3 = 1 pulses `adj30_o` for one cycle.
- R9: Address 0xF stores reset in bit 0, stop in bit 1 and 24-hour mode in bit 2. These drive `ctl_rest_o`, `ctl_stop_o` and `ctl_h24_o`. Bit 3 (test) is discarded on write and reads 0.
- R10: `carry_grant_o` pulses one cycle after a clock on which `carry_req_i` is 1, the freeze bit is 0 and busy is 0. No grant is given while the freeze bit is set.
- R11: After reset, all control bits, busy and every output pulse are 0, and `bus_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ale | input | 1 | Address strobe, 1 = address transparent |
| bus_cs0_n | input | 1 | Active-low chip select |
| bus_cs1 | input | 1 | Active-high chip select |
| bus_addr | input | 4 | Register address pins |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_din | input | 4 | Data from host |
| bus_dout | output | 4 | Data to host |
| bus_doe | output | 1 | Data bus drive enable |
| ext_rd_addr | output | 4 | Effective address to owning blocks |
| ext_rd_data | input | 4 | Read data from owning blocks |
| ext_wr_o | output | 1 | One-cycle forwarded write pulse |
| ext_wr_addr | output | 4 | Forwarded write address |
| ext_wr_data | output | 4 | Forwarded write data |
| irq_flag_i | input | 1 | Interrupt flag from interrupt block |
| irq_clr_o | output | 1 | Interrupt flag clear pulse |
| adj30_o | output | 1 | Half-minute adjust pulse |
| carry_req_i | input | 1 | Timekeeper carry request, held until granted |
| carry_grant_o | output | 1 | Carry grant pulse |
| ctl_rest_o | output | 1 | Counter reset control |
| ctl_stop_o | output | 1 | Counter stop control |
| ctl_h24_o | output | 1 | 1 = 24-hour mode |

## Verification
A wrong held address appears on `ext_rd_addr` and in the read nibble on the first cycle that follows the fall of the address strobe. A stale write-capture register appears as a wrong address or data on the forwarded pulse, in the cycle after the synchronized write strobe rises. A busy counter that is off by one shifts the next grant. It also changes bit 1 of a 0xD read in the cycle where the window should open or close. A leaked freeze or control bit shows on the control outputs, or on the next grant, within one cycle of the write.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
  localparam int NB_AW = 4;
  localparam int NB_DW = 4;

  localparam logic [NB_AW-1:0] REG_CTL_D = 4'hD;
  localparam logic [NB_AW-1:0] REG_CTL_F = 4'hF;

  // control register D bit positions
  localparam int D_HOLD = 0;
  localparam int D_BUSY = 1;
  localparam int D_IRQ  = 2;
  localparam int D_ADJ  = 3;
  // control register F bit positions
  localparam int F_REST = 0;
  localparam int F_STOP = 1;
  localparam int F_H24  = 2;

  typedef struct packed {
    logic             ale;
    logic             cs0_n;
    logic             cs1;
    logic             rd_n;
    logic             wr_n;
    logic [NB_AW-1:0] addr;
    logic [NB_DW-1:0] data;
  } bus_smp_t;

  localparam int SMP_W = $bits(bus_smp_t);

  typedef struct packed {
    logic             vld;
    logic [NB_AW-1:0] addr;
    logic [NB_DW-1:0] data;
  } nb_wr_t;

  function automatic logic is_local(input logic [NB_AW-1:0] a);
    return (a == REG_CTL_D) || (a == REG_CTL_F);
  endfunction
endpackage

// File: rtl/nbus_sync.sv
module nbus_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] stg_nx;
    if (i == 0) begin : g_first
      always_comb stg_nx = d;
    end else begin : g_next
      always_comb stg_nx = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg_nx;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nbus_decode.sv
module nbus_decode
  import nbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_smp_t         smp,
  output logic [NB_AW-1:0] eff_addr,
  output logic             rd_act,
  output nb_wr_t           wr_ev
);
  logic             sel;
  logic [NB_AW-1:0] addr_q,  addr_nx;
  logic             wrn_q,   wrn_nx;
  logic             wsel_q,  wsel_nx;
  logic [NB_AW-1:0] waddr_q, waddr_nx;
  logic [NB_DW-1:0] wdata_q, wdata_nx;
  logic             cap_en;

  always_comb begin
    sel      = ~smp.cs0_n & smp.cs1;
    eff_addr = smp.ale ? smp.addr : addr_q;
    rd_act   = sel & ~smp.rd_n;
    cap_en   = ~smp.wr_n;

    addr_nx  = smp.ale ? smp.addr : addr_q;
    wrn_nx   = smp.wr_n;
    wsel_nx  = cap_en ? sel      : wsel_q;
    waddr_nx = cap_en ? eff_addr : waddr_q;
    wdata_nx = cap_en ? smp.data : wdata_q;

    wr_ev.vld  = smp.wr_n & ~wrn_q & wsel_q;
    wr_ev.addr = waddr_q;
    wr_ev.data = wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wrn_q   <= 1'b1;
      wsel_q  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_nx;
      wrn_q   <= wrn_nx;
      wsel_q  <= wsel_nx;
      waddr_q <= waddr_nx;
      wdata_q <= wdata_nx;
    end
  end
endmodule

// File: rtl/nbus_regs.sv
module nbus_regs
  import nbus_pkg::*;
#(
  parameter int BUSY_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  nb_wr_t           wr_ev,
  input  logic             carry_req,
  output logic             hold,
  output logic             busy,
  output logic             rest,
  output logic             stop,
  output logic             h24,
  output logic             irq_clr,
  output logic             adj30,
  output logic             grant,
  output logic             ext_wr,
  output logic [NB_AW-1:0] ext_addr,
  output logic [NB_DW-1:0] ext_data
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic             wr_d, wr_f, wr_x, go;
  logic             hold_nx, rest_nx, stop_nx, h24_nx;
  logic             irq_clr_nx, adj30_nx, grant_nx, ext_wr_nx;
  logic [NB_AW-1:0] ext_addr_nx;
  logic [NB_DW-1:0] ext_data_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    wr_d = wr_ev.vld & (wr_ev.addr == REG_CTL_D);
    wr_f = wr_ev.vld & (wr_ev.addr == REG_CTL_F);
    wr_x = wr_ev.vld & ~is_local(wr_ev.addr);
    busy = (cnt_q != '0);
    go   = carry_req & ~hold & ~busy;

    hold_nx = wr_d ? wr_ev.data[D_HOLD] : hold;
    rest_nx = wr_f ? wr_ev.data[F_REST] : rest;
    stop_nx = wr_f ? wr_ev.data[F_STOP] : stop;
    h24_nx  = wr_f ? wr_ev.data[F_H24]  : h24;

    irq_clr_nx  = wr_d & ~wr_ev.data[D_IRQ];
    adj30_nx    = wr_d &  wr_ev.data[D_ADJ];
    ext_wr_nx   = wr_x;
    ext_addr_nx = wr_x ? wr_ev.addr : ext_addr;
    ext_data_nx = wr_x ? wr_ev.data : ext_data;

    grant_nx = go;
    if (go)        cnt_nx = CNT_LOAD;
    else if (busy) cnt_nx = cnt_q - 1'b1;
    else           cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= 1'b0;
      rest     <= 1'b0;
      stop     <= 1'b0;
      h24      <= 1'b0;
      irq_clr  <= 1'b0;
      adj30    <= 1'b0;
      grant    <= 1'b0;
      ext_wr   <= 1'b0;
      ext_addr <= '0;
      ext_data <= '0;
      cnt_q    <= '0;
    end else begin
      hold     <= hold_nx;
      rest     <= rest_nx;
      stop     <= stop_nx;
      h24      <= h24_nx;
      irq_clr  <= irq_clr_nx;
      adj30    <= adj30_nx;
      grant    <= grant_nx;
      ext_wr   <= ext_wr_nx;
      ext_addr <= ext_addr_nx;
      ext_data <= ext_data_nx;
      cnt_q    <= cnt_nx;
    end
  end
endmodule

// File: rtl/nbus_regif.sv
module nbus_regif
  import nbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_ale,
  input  logic             bus_cs0_n,
  input  logic             bus_cs1,
  input  logic [NB_AW-1:0] bus_addr,
  input  logic             bus_rd_n,
  input  logic             bus_wr_n,
  input  logic [NB_DW-1:0] bus_din,
  output logic [NB_DW-1:0] bus_dout,
  output logic             bus_doe,
  output logic [NB_AW-1:0] ext_rd_addr,
  input  logic [NB_DW-1:0] ext_rd_data,
  output logic             ext_wr_o,
  output logic [NB_AW-1:0] ext_wr_addr,
  output logic [NB_DW-1:0] ext_wr_data,
  input  logic             irq_flag_i,
  output logic             irq_clr_o,
  output logic             adj30_o,
  input  logic             carry_req_i,
  output logic             carry_grant_o,
  output logic             ctl_rest_o,
  output logic             ctl_stop_o,
  output logic             ctl_h24_o
);
  localparam bus_smp_t SMP_IDLE = '{ale: 1'b0, cs0_n: 1'b1, cs1: 1'b0,
                                    rd_n: 1'b1, wr_n: 1'b1,
                                    addr: '0, data: '0};

  // reset: asserted at once, released on the clock
  logic [1:0] rsync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  bus_smp_t raw, smp;
  assign raw = '{ale: bus_ale, cs0_n: bus_cs0_n, cs1: bus_cs1,
                 rd_n: bus_rd_n, wr_n: bus_wr_n,
                 addr: bus_addr, data: bus_din};

  logic [SMP_W-1:0] smp_vec;
  nbus_sync #(.W(SMP_W), .STAGES(SYNC_STAGES), .RST_VAL(SMP_IDLE)) i_sync (
    .clk(clk), .rst_n(rst_i), .d(raw), .q(smp_vec)
  );
  assign smp = bus_smp_t'(smp_vec);

  logic [NB_AW-1:0] eff_addr;
  logic             rd_act;
  nb_wr_t           wr_ev;

  nbus_decode i_dec (
    .clk(clk), .rst_n(rst_i), .smp(smp),
    .eff_addr(eff_addr), .rd_act(rd_act), .wr_ev(wr_ev)
  );

  logic hold, busy, rest, stop, h24;

  nbus_regs #(.BUSY_CYCLES(BUSY_CYCLES)) i_regs (
    .clk(clk), .rst_n(rst_i), .wr_ev(wr_ev), .carry_req(carry_req_i),
    .hold(hold), .busy(busy), .rest(rest), .stop(stop), .h24(h24),
    .irq_clr(irq_clr_o), .adj30(adj30_o), .grant(carry_grant_o),
    .ext_wr(ext_wr_o), .ext_addr(ext_wr_addr), .ext_data(ext_wr_data)
  );

  logic [NB_DW-1:0] rd_mux;
  always_comb begin
    rd_mux = ext_rd_data;
    if (eff_addr == REG_CTL_D) begin
      rd_mux         = '0;
      rd_mux[D_HOLD] = hold;
      rd_mux[D_BUSY] = busy;
      rd_mux[D_IRQ]  = irq_flag_i;
    end else if (eff_addr == REG_CTL_F) begin
      rd_mux         = '0;
      rd_mux[F_REST] = rest;
      rd_mux[F_STOP] = stop;
      rd_mux[F_H24]  = h24;
    end
  end

  assign ext_rd_addr = eff_addr;
  assign bus_doe     = rd_act;
  assign bus_dout    = rd_act ? rd_mux : '0;
  assign ctl_rest_o  = rest;
  assign ctl_stop_o  = stop;
  assign ctl_h24_o   = h24;
endmodule

// File: rtl/nbus_regif_chk.sv
module nbus_regif_chk
  import nbus_pkg::*;
(
  input logic             clk,
  input logic             rst_i,
  input logic             bus_doe,
  input logic [NB_DW-1:0] bus_dout,
  input logic [NB_AW-1:0] rd_addr,
  input logic             ext_wr_o,
  input logic [NB_AW-1:0] ext_wr_addr,
  input logic             irq_clr_o,
  input logic             adj30_o,
  input logic             carry_req_i,
  input logic             carry_grant_o,
  input logic             hold,
  input logic             busy
);
  a_r3_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_i)
    !bus_doe |-> (bus_dout == '0));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    ext_wr_o |=> !ext_wr_o);
  a_r4_local_kept: assert property (@(posedge clk) disable iff (!rst_i)
    ext_wr_o |-> (ext_wr_addr != REG_CTL_D) && (ext_wr_addr != REG_CTL_F));
  a_r5_adj_reads_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_doe && rd_addr == REG_CTL_D) |-> !bus_dout[D_ADJ]);
  a_r7_clear_single: assert property (@(posedge clk) disable iff (!rst_i)
    irq_clr_o |=> !irq_clr_o);
  a_r8_adj_single: assert property (@(posedge clk) disable iff (!rst_i)
    adj30_o |=> !adj30_o);
  a_r9_test_reads_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_doe && rd_addr == REG_CTL_F) |-> !bus_dout[3]);
  a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_i)
    carry_grant_o |-> $past(carry_req_i));
  a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_i)
    carry_grant_o |-> !$past(hold));
  a_r6_busy_on_grant: assert property (@(posedge clk) disable iff (!rst_i)
    carry_grant_o |-> busy);
endmodule

bind nbus_regif nbus_regif_chk i_chk (
  .clk(clk), .rst_i(rst_i), .bus_doe(bus_doe), .bus_dout(bus_dout),
  .rd_addr(eff_addr), .ext_wr_o(ext_wr_o), .ext_wr_addr(ext_wr_addr),
  .irq_clr_o(irq_clr_o), .adj30_o(adj30_o), .carry_req_i(carry_req_i),
  .carry_grant_o(carry_grant_o), .hold(hold), .busy(busy)
);

// File: tb/test_nbus_regif.sv
module test_nbus_regif;
  localparam int SYNC = 2;
  localparam int BUSY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, cs0_n = 1'b1, cs1 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0, din = '0;
  logic [3:0] dout, rd_addr, rd_data, wa, wd;
  logic       doe, ewr, irq_flag = 1'b0, iclr, adj, creq = 1'b0, grant;
  logic       rest, stop, h24;

  int n_chk = 0, n_err = 0;
  int cnt_ext = 0, cnt_clr = 0, cnt_adj = 0, cnt_grant = 0;
  logic [3:0] last_wa, last_wd;

  always #2 clk = ~clk;

  assign rd_data = rd_addr ^ 4'hA;

  nbus_regif #(.SYNC_STAGES(SYNC), .BUSY_CYCLES(BUSY)) i_nbus_regif (
    .clk(clk), .rst_n(rst_n), .bus_ale(ale), .bus_cs0_n(cs0_n), .bus_cs1(cs1),
    .bus_addr(addr), .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_din(din),
    .bus_dout(dout), .bus_doe(doe), .ext_rd_addr(rd_addr), .ext_rd_data(rd_data),
    .ext_wr_o(ewr), .ext_wr_addr(wa), .ext_wr_data(wd), .irq_flag_i(irq_flag),
    .irq_clr_o(iclr), .adj30_o(adj), .carry_req_i(creq), .carry_grant_o(grant),
    .ctl_rest_o(rest), .ctl_stop_o(stop), .ctl_h24_o(h24)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [12:0] m_q[$];
  logic [1:0]  m_rs;
  logic [3:0]  m_aq, m_wa, m_wd, m_ea, m_ed;
  logic        m_wrn, m_wsel, m_hold, m_rest, m_stop, m_h24;
  logic        m_ewr, m_clr, m_adj, m_grant;
  int          m_cnt;

  task automatic m_reset();
    m_q = {};
    for (int i = 0; i < SYNC; i++) m_q.push_back(13'b0_1_0_1_1_0000_0000);
    m_aq = 0; m_wrn = 1; m_wsel = 0; m_wa = 0; m_wd = 0;
    m_hold = 0; m_rest = 0; m_stop = 0; m_h24 = 0;
    m_ewr = 0; m_clr = 0; m_adj = 0; m_grant = 0; m_ea = 0; m_ed = 0; m_cnt = 0;
  endtask

  task automatic m_step();
    logic [12:0] s;
    logic sel, ev, go;
    logic [3:0] eff;
    s   = m_q[SYNC-1];
    sel = !s[11] && s[10];
    eff = s[12] ? s[7:4] : m_aq;
    ev  = s[8] && !m_wrn && m_wsel;
    m_ewr = ev && m_wa != 4'hD && m_wa != 4'hF;
    if (m_ewr) begin m_ea = m_wa; m_ed = m_wd; end
    m_clr = ev && m_wa == 4'hD && !m_wd[2];
    m_adj = ev && m_wa == 4'hD && m_wd[3];
    go = creq && !m_hold && m_cnt == 0;
    m_grant = go;
    m_cnt = go ? BUSY : (m_cnt > 0 ? m_cnt - 1 : 0);
    if (ev && m_wa == 4'hD) m_hold = m_wd[0];
    if (ev && m_wa == 4'hF) {m_h24, m_stop, m_rest} = m_wd[2:0];
    if (s[12]) m_aq = s[7:4];
    if (!s[8]) begin m_wsel = sel; m_wa = eff; m_wd = s[3:0]; end
    m_wrn = s[8];
    void'(m_q.pop_back());
    m_q.push_front({ale, cs0_n, cs1, rd_n, wr_n, addr, din});
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_rs = 2'b00; m_reset(); end
    else begin
      if (!m_rs[1]) m_reset(); else m_step();
      m_rs = {m_rs[0], 1'b1};
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [12:0] s;
      logic rd;
      logic [3:0] eff, mux;
      s   = m_q[SYNC-1];
      rd  = !s[11] && s[10] && !s[9];
      eff = s[12] ? s[7:4] : m_aq;
      if (eff == 4'hD)      mux = {1'b0, irq_flag, m_cnt != 0, m_hold};
      else if (eff == 4'hF) mux = {1'b0, m_h24, m_stop, m_rest};
      else                  mux = eff ^ 4'hA;
      chk("R2 ext_rd_addr", rd_addr, eff);
      chk("R3 bus_doe", doe, rd);
      chk(eff == 4'hD ? "R5 dout" : (eff == 4'hF ? "R9 dout" : "R3 dout"),
          dout, rd ? mux : 4'h0);
      chk("R4 ext_wr_o", ewr, m_ewr);
      if (m_ewr) begin
        chk("R4 ext_wr_addr", wa, m_ea);
        chk("R4 ext_wr_data", wd, m_ed);
      end
      chk("R7 irq_clr_o", iclr, m_clr);
      chk("R8 adj30_o", adj, m_adj);
      chk("R10 carry_grant_o", grant, m_grant);
      chk("R9 ctl outputs", {rest, stop, h24}, {m_rest, m_stop, m_h24});
      if (ewr) begin cnt_ext++; last_wa = wa; last_wd = wd; end
      if (iclr) cnt_clr++;
      if (adj) cnt_adj++;
      if (grant) begin cnt_grant++; creq = 1'b0; end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [3:0] a, input logic [3:0] d,
                           input logic c0n, input logic c1);
    @(negedge clk); cs0_n = c0n; cs1 = c1; addr = a; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); wr_n = 1'b0; din = d;
    @(negedge clk);
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs0_n = 1'b1; cs1 = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [3:0] a_after,
                          input logic tied, input logic c0n,
                          input logic exp_oe, input logic [3:0] exp,
                          input string tag);
    @(negedge clk); cs0_n = c0n; cs1 = 1'b1; addr = a; ale = 1'b1;
    @(negedge clk); ale = tied; addr = a_after; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(tag, doe, exp_oe);
    if (exp_oe) chk(tag, dout, exp);
    @(negedge clk); rd_n = 1'b1; cs0_n = 1'b1; cs1 = 1'b0; ale = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11 doe after reset", doe, 0);
    chk("R11 controls after reset", {rest, stop, h24, grant, ewr}, 0);

    // R9 control register F, test bit discarded
    bus_write(4'hF, 4'hF, 1'b0, 1'b1);
    bus_read(4'hF, 4'hF, 1'b0, 1'b0, 1'b1, 4'h7, "R9 read F");
    chk("R9 control pins", {rest, stop, h24}, 3'b111);
    bus_write(4'hF, 4'h4, 1'b0, 1'b1);

    // R5/R6: hold set, busy write ignored, irq flag visible
    irq_flag = 1'b1;
    bus_write(4'hD, 4'b0011, 1'b0, 1'b1);
    bus_read(4'hD, 4'hD, 1'b0, 1'b0, 1'b1, 4'b0101, "R5 R6 read D");
    chk("R7 clear pulse on bit2=0", cnt_clr, 1);

    // R10: request held while frozen
    @(negedge clk); creq = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 no grant while hold", cnt_grant, 0);
    bus_write(4'hD, 4'b0100, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R10 one grant after release", cnt_grant, 1);
    chk("R7 no pulse on bit2=1", cnt_clr, 1);

    // R8 adjust pulse
    bus_write(4'hD, 4'b1100, 1'b0, 1'b1);
    chk("R8 adjust pulse", cnt_adj, 1);

    // R4 forwarded write
    bus_write(4'h3, 4'h9, 1'b0, 1'b1);
    chk("R4 forwarded count", cnt_ext, 1);
    chk("R4 forwarded addr/data", {last_wa, last_wd}, 8'h39);
    bus_write(4'hE, 4'h6, 1'b0, 1'b1);
    chk("R4 forwarded E", {cnt_ext[3:0], last_wa, last_wd}, 12'h2E6);

    // R1 selects must both be active
    bus_write(4'h4, 4'h1, 1'b0, 1'b0);
    bus_write(4'h4, 4'h1, 1'b1, 1'b1);
    chk("R1 write without select", cnt_ext, 2);
    bus_read(4'h4, 4'h4, 1'b0, 1'b1, 1'b0, 4'h0, "R1 read without select");

    // R2 address latch and transparent strobe
    bus_read(4'h5, 4'h7, 1'b0, 1'b0, 1'b1, 4'hF, "R2 held address");
    bus_read(4'h2, 4'h2, 1'b1, 1'b0, 1'b1, 4'h8, "R2 transparent address");

    // R6 busy bit is read-only
    irq_flag = 1'b0;
    bus_write(4'hD, 4'b0010, 1'b0, 1'b1);
    bus_read(4'hD, 4'hD, 1'b0, 1'b0, 1'b1, 4'h0, "R6 busy write ignored");

    // R6 busy window length, observed through reads of D during a grant
    @(negedge clk); cs0_n = 1'b0; cs1 = 1'b1; addr = 4'hD; ale = 1'b1; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    creq = 1'b1;
    repeat (BUSY + 6) @(negedge clk);
    rd_n = 1'b1; cs0_n = 1'b1; cs1 = 1'b0; ale = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 second grant", cnt_grant, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule